// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

A synchronous single-port memory for a register-to-register datapath. Every control, the address and the write data are captured on the rising clock edge. A burst opens when either of two address strobes is asserted: a controller strobe or a processor strobe. The block then steps through up to four words on its own, using a 2-bit counter that advances only while the advance input is low. A static mode input picks the order of those words. In linear order the count is added to the two low start-address bits. In interleaved order the count is XORed with them.

The data bus is shared and bidirectional. Reads are pipelined: the word for an access registered on one edge is loaded into the output register on the next edge. It is driven onto the bus only while the asynchronous output enable is low. Writes take the word from the same bus. They either update selected 9-bit lanes, through per-lane enables that a common byte-write enable gates, or update every lane, through a global write input that overrides the lane enables. All controls are active low except the second chip select and the mode input.

Top module: `burst_sram`

## Requirements
- R1: The controller strobe (`cstb_n` low) loads `addr` and the chip-select state on the rising edge. The burst is active when `sel_n` is low and `sel2` is high. A controller strobe sampled while deselected performs no access and writes nothing.
- R2: The processor strobe (`pstb_n` low with `cstb_n` high) starts a read burst at `addr` only when `sel_n` is low. With `sel_n` high it is ignored: the running burst continues as if no strobe were present. When both strobes are low, the controller strobe wins.
- R3: Without a strobe, the 2-bit burst count steps by one on each edge where `adv_n` is low and holds otherwise. It wraps from 3 to 0. The address bits above bit 1 stay those of the start address.
- R4: With `mode_il` = 0, the low two address bits of burst word k are (start[1:0] + k) mod 4.
- R5: With `mode_il` = 1, the low two address bits of burst word k are start[1:0] XOR k.
- R6: With `gw_n` high and `bwe_n` low, lane i (bus bits 9i+8 down to 9i) is written where `bw_n[i]` = 0, and the other lanes keep their contents. If `bwe_n` is high or all `bw_n` bits are 1, the access is a read, whatever `bw_n` holds.
- R7: With `gw_n` low, every lane is written, regardless of `bwe_n` and `bw_n`.
- R8: A read access registered on edge k puts its word on `dq` after edge k+1. The word stays there until the next edge.
- R9: With `oe_n` high, `dq` is high impedance. `oe_n` acts without waiting for a clock edge.
- R10: After a cycle whose access is not a read (deselected, idle or write), the block releases `dq` at the following edge.
- R11: During and right after reset, no burst is active and `dq` is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Start address of a burst |
| cstb_n | input | 1 | Controller address strobe, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip select, active low |
| sel2 | input | 1 | Secondary chip select, active high |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane write enables, active low |
| gw_n | input | 1 | Global write, active low |
| mode_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| dq | inout | LANES*LANE_W | Shared data bus |

## Verification
Two functions can fall in the same cycle. In the first, a burst step (the counter advancing) meets a processor strobe that arrives while deselected. The bench advances a running burst in that very cycle and expects the next word in burst order, not the new address. In the second, the output stage still holds a read word while the bench drives write data onto the bus. The bench raises the output enable in those cycles, then reads back both the merged lanes and the untouched words. In both orders, sweeping the start address over the whole array covers every wrap of the counter.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      cstb_n,
  input  logic                      pstb_n,
  input  logic                      adv_n,
  input  logic                      sel_n,
  input  logic                      sel2,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic                      gw_n,
  input  logic                      mode_il,
  input  logic                      oe_n,
  inout  wire  [LANES*LANE_W-1:0]   dq
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic logic [1:0] order(input logic [1:0] b, input logic [1:0] k, input logic il);
    return il ? (b ^ k) : (b + k);
  endfunction

  logic [ADDR_W-1:0] base_q, base_nx, ea, ea_q;
  logic [1:0]        cnt_q, cnt_nx;
  logic              act_q, acc_nx, acc_q, wr_q, drv;
  logic [LANES-1:0]  wmask_q, mask_now;
  logic [DATA_W-1:0] wd_q, dout;

  wire start_c = !cstb_n;
  wire start_p = cstb_n && !pstb_n && !sel_n;
  wire start   = start_c || start_p;
  wire wr_now  = !gw_n || (!bwe_n && !(&bw_n));

  assign mask_now = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
  assign base_nx  = start ? addr : base_q;
  assign cnt_nx   = start ? 2'd0 : ((act_q && !adv_n) ? cnt_q + 2'd1 : cnt_q);
  assign acc_nx   = start_c ? (!sel_n && sel2) : (start_p ? sel2 : act_q);
  assign ea       = {base_nx[ADDR_W-1:2], order(base_nx[1:0], cnt_nx, mode_il)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      acc_q   <= 1'b0;
      wr_q    <= 1'b0;
      ea_q    <= '0;
      wmask_q <= '0;
      wd_q    <= '0;
    end else begin
      base_q  <= base_nx;
      cnt_q   <= cnt_nx;
      act_q   <= acc_nx;
      acc_q   <= acc_nx;
      wr_q    <= start_p ? 1'b0 : wr_now;
      ea_q    <= ea;
      wmask_q <= mask_now;
      wd_q    <= dq;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (acc_q && wr_q && wmask_q[i])
        mem[ea_q] <= wd_q[i*LANE_W +: LANE_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dout[i*LANE_W +: LANE_W] <= '0;
      else if (acc_q && !wr_q)
        dout[i*LANE_W +: LANE_W] <= mem[ea_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv <= 1'b0;
    else        drv <= acc_q && !wr_q;
  end

  assign dq = (drv && !oe_n) ? dout : {DATA_W{1'bz}};
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cstb_n,
  input logic              pstb_n,
  input logic              adv_n,
  input logic              sel_n,
  input logic              sel2,
  input logic              gw_n,
  input logic              acc_q,
  input logic              wr_q,
  input logic [LANES-1:0]  wmask_q,
  input logic              drv,
  input logic [ADDR_W-1:0] base_q,
  input logic              act_q,
  input logic [1:0]        cnt_q
);
  // R1
  deselect_noacc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n && !(!sel_n && sel2)) |=> (!acc_q && !act_q));

  // R2
  pstb_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cstb_n && !pstb_n && sel_n) |=> ($stable(base_q) && $stable(act_q)));

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cstb_n && (pstb_n || sel_n) && adv_n) |=> $stable(cnt_q));

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && cstb_n && (pstb_n || sel_n) && !adv_n && cnt_q == 2'd3) |=> (cnt_q == 2'd0));

  // R7
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cstb_n && !sel_n && sel2 && !gw_n) |=> (acc_q && wr_q && (&wmask_q)));

  // R8
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !wr_q) |=> drv);

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_q || wr_q) |=> !drv);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) chk_i (.*);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam logic [DW-1:0] RELEASED = {DW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic cstb_n, pstb_n, adv_n, sel_n, sel2, bwe_n, gw_n, mode_il, oe_n;
  logic [1:0] bw_n;
  logic tb_en;
  logic [DW-1:0] tb_d;
  tri1 [DW-1:0] dq;
  assign dq = tb_en ? tb_d : {DW{1'bz}};

  int total = 0, bad = 0;
  logic [DW-1:0] model [64];

  always #(CLK_P/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cstb_n(cstb_n), .pstb_n(pstb_n),
    .adv_n(adv_n), .sel_n(sel_n), .sel2(sel2), .bwe_n(bwe_n), .bw_n(bw_n),
    .gw_n(gw_n), .mode_il(mode_il), .oe_n(oe_n), .dq(dq));

  function automatic logic [DW-1:0] pat(int a);
    return {1'b0, 17'(a * 4099 + 777)};
  endfunction

  function automatic logic [AW-1:0] baddr(logic [AW-1:0] s, int k, logic il);
    logic [1:0] kk = 2'(k);
    return {s[AW-1:2], il ? (s[1:0] ^ kk) : (s[1:0] + kk)};
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    cstb_n = 1; pstb_n = 1; adv_n = 1; sel_n = 0; sel2 = 1;
    bwe_n = 1; bw_n = 2'b11; gw_n = 1; oe_n = 0; tb_en = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic deselect();
    idle_in(); cstb_n = 0; sel_n = 1; step();
  endtask

  task automatic write(logic [AW-1:0] a, logic [DW-1:0] d, logic bwe, logic [1:0] bwn, logic gw, logic s2);
    idle_in(); cstb_n = 0; addr = a; bwe_n = bwe; bw_n = bwn; gw_n = gw; sel2 = s2;
    oe_n = 1; tb_en = 1; tb_d = d;
    step();
    deselect();
  endtask

  task automatic read1(logic [AW-1:0] a, string tag);
    idle_in(); pstb_n = 0; addr = a; step();
    deselect();
    chk(tag, dq, model[a]);
    idle_in(); step();
    chk("R10 bus released after read", dq, RELEASED);
  endtask

  task automatic burst(logic [AW-1:0] a, logic il);
    idle_in(); mode_il = il; pstb_n = 0; addr = a; step();
    for (int k = 1; k <= 4; k++) begin
      idle_in(); adv_n = 0; step();
      chk(il ? "R5 interleaved word" : "R4 linear word", dq, model[baddr(a, k - 1, il)]);
    end
    deselect();
    chk("R3 wrap to start", dq, model[baddr(a, 4, il)]);
    idle_in(); step();
    chk("R10 released after deselect", dq, RELEASED);
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_in(); addr = '0; mode_il = 0; tb_d = '0;
    repeat (3) step();
    chk("R11 bus idle in reset", dq, RELEASED);
    rst_n = 1;
    step();
    chk("R11 bus idle after reset", dq, RELEASED);

    // R7: fill through global write with lane enables all inactive
    for (int a = 0; a < 64; a++) begin
      idle_in(); cstb_n = 0; addr = AW'(a); gw_n = 0; oe_n = 1; tb_en = 1; tb_d = pat(a);
      step();
      model[a] = pat(a);
    end
    deselect();
    read1(6'd5, "R7 global write");
    read1(6'd63, "R7 global write top");

    // R4 R5 R3: every start address in both orders
    for (int il = 0; il < 2; il++)
      for (int a = 0; a < 64; a++) burst(AW'(a), il[0]);

    // R6: partial lane writes
    write(6'd10, 18'h2A5A5, 0, 2'b10, 1, 1);
    model[10][8:0] = 9'h1A5;
    read1(6'd10, "R6 lane0 only");
    write(6'd11, 18'h15555, 0, 2'b01, 1, 1);
    model[11][17:9] = 9'h0AA;
    read1(6'd11, "R6 lane1 only");
    write(6'd12, 18'h00000, 1, 2'b00, 1, 1);
    read1(6'd12, "R6 lanes ignored without bwe_n");
    write(6'd13, 18'h3FFFE, 0, 2'b11, 1, 1);
    read1(6'd13, "R6 no lane selected");
    // R7: global write overrides lane enables
    write(6'd14, 18'h12345, 1, 2'b11, 0, 1);
    model[14] = 18'h12345;
    read1(6'd14, "R7 override");
    write(6'd15, 18'h0ABCD, 0, 2'b10, 0, 1);
    model[15] = 18'h0ABCD;
    read1(6'd15, "R7 override with partial enables");

    // R1: deselected controller strobe writes nothing
    write(6'd20, 18'h01111, 1, 2'b11, 0, 0);
    read1(6'd20, "R1 deselected write ignored");

    // R2: processor strobe while deselected is ignored mid-burst
    idle_in(); mode_il = 0; pstb_n = 0; addr = 6'd32; step();
    idle_in(); adv_n = 0; step();
    chk("R2 burst word0", dq, model[32]);
    idle_in(); adv_n = 0; pstb_n = 0; sel_n = 1; addr = 6'd50; step();
    chk("R2 burst word1", dq, model[33]);
    deselect();
    chk("R2 ignored strobe, burst continues", dq, model[34]);
    idle_in(); step();

    // R2: controller strobe wins over processor strobe
    idle_in(); cstb_n = 0; pstb_n = 0; addr = 6'd40; gw_n = 0; oe_n = 1; tb_en = 1; tb_d = 18'h0F0F0;
    step();
    model[40] = 18'h0F0F0;
    deselect();
    read1(6'd40, "R2 controller priority write");

    // R8 R9: pipelined read, async output enable
    idle_in(); pstb_n = 0; addr = 6'd7; step();
    chk("R8 nothing yet one edge after address", dq, RELEASED);
    idle_in(); cstb_n = 0; sel_n = 1; oe_n = 1; step();
    chk("R9 oe_n high floats bus", dq, RELEASED);
    oe_n = 0; #1;
    chk("R9 oe_n low drives without edge", dq, model[7]);
    oe_n = 1; #1;
    chk("R9 oe_n high floats without edge", dq, RELEASED);
    idle_in(); step();
    chk("R10 released", dq, RELEASED);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule